// File: doc/BRIEF.md
# Edge Event Timestamp Capture

This block watches eight external event pins. When a pin makes an edge that software has enabled, the block copies the seconds and nanoseconds value of a free-running local time counter into a holding register for that pin and that edge direction. Each pin therefore has two pairs of holding registers: one pair for rising edges and one pair for falling edges. Every captured edge raises a sticky status bit. Status bits are write-one-to-clear, and each one has its own interrupt enable. The interrupt output is active while any enabled status bit is pending.

Each pin and edge direction has a lock bit. While the lock bit is set and the status bit for that pin and edge is pending, later edges of the same kind leave the held timestamp untouched. Clearing the status bit re-arms the capture. A 3-bit channel select field chooses which pin's four holding registers appear at the shared read addresses.

Each pin and edge pair is tracked by a small three-state controller:
- `CS_OFF`: capture disabled.
- `CS_ARMED`: capture enabled, and the next edge is accepted.
- `CS_HELD`: locked and pending, so edges are refused.

Its transitions are:
- `T_ENABLE`: `CS_OFF` to `CS_ARMED` when capture is enabled.
- `T_LOCK`: `CS_ARMED` to `CS_HELD` when the lock bit is set and the status bit is pending after the cycle.
- `T_RELEASE`: `CS_HELD` to `CS_ARMED` on a status clear or when the lock drops.
- `T_DISABLE`: any state to `CS_OFF` when capture is disabled.

Pins pass through a two-flop synchronizer before edge detection.

Top module: `edge_stamp_capture`

## Requirements
- R1: After reset, every register reads zero and `irq` is low. The register word addresses on `bus_addr` are:
  - 0: capture config
  - 1: status
  - 2: enable-set
  - 3: enable-clear
  - 4: channel select
  - 5: rising seconds
  - 6: rising nanoseconds
  - 7: falling seconds
  - 8: falling nanoseconds
- R2: Rising-edge capture works as follows when capture-config bit ch (rising enable) is set.
  - A 0-to-1 change on `ev_in[ch]` that has been stable for a cycle latches `ltc_sec` and `ltc_ns` into that channel's rising registers.
  - The same change sets status bit 16+ch.
  - Both results are visible once the third rising clock edge after the pin change has passed.
- R3: Falling-edge capture works the same way. With capture-config bit 8+ch set, a 1-to-0 change on `ev_in[ch]` latches the time into the channel's falling registers and sets status bit 24+ch, with the same latency.
- R4: A disabled edge direction captures nothing and sets no status, even when the other direction of the same pin is enabled.
- R5: Locking uses capture-config bits 16+ch (rising lock) and 24+ch (falling lock).
  - While a lock bit is set and the matching status bit is pending, further edges of that kind leave the held value unchanged.
  - After the status bit is cleared, the next such edge captures again.
- R6: With the lock bit clear, each new enabled edge overwrites the held value, even while the status bit is pending.
- R7: Writing the status address clears every status bit written as 1 and leaves bits written as 0 unchanged.
- R8: Interrupt enables occupy the same bit positions as status.
  - Writing 1s to the enable-set address turns those enables on.
  - Writing 1s to the enable-clear address turns those enables off.
  - Zero bits in either write leave the enables unchanged.
  - Both addresses read back the current enables.
- R9: `irq` is high exactly when some status bit is pending with its enable set.
- R10: Channel select bits 10:8 choose the channel shown at addresses 5 to 8. Nanoseconds are 30 bits wide and read back zero-extended, so bits 31:30 read as 0. Each channel's captures remain independent of the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_in | input | 8 | Asynchronous event pins |
| ltc_sec | input | 32 | Local time counter, seconds |
| ltc_ns | input | 30 | Local time counter, nanoseconds |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from address) |
| irq | output | 1 | Interrupt, OR of enabled pending status |

## Verification
The hardest situation to reach is the held state: a locked channel with its status pending that then sees another edge of the same kind. Reaching it also requires proving that the refused edge changed nothing. The stimulus first enables only one pin's rising capture with its lock bit set. It then raises the pin at time X, drops it (the falling direction is disabled), and raises it again with the time counter moved to Y. The held value is read back expecting X. The status bit is then cleared and a third rise at Z must be captured. Every pin and direction is also swept with arithmetically distinct time values, so a capture landing in the wrong slot shows up.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
    localparam int NUM_CH   = 8;
    localparam int FIELD_W  = 8;
    localparam int SEC_W    = 32;
    localparam int NS_W     = 30;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;
    localparam int SEL_W    = 3;
    localparam int SEL_LSB  = 8;
    localparam int STAT_LSB = 16;
    localparam int LOCK_LSB = 16;

    localparam logic [ADDR_W-1:0] RA_CFG    = 4'd0;
    localparam logic [ADDR_W-1:0] RA_STAT   = 4'd1;
    localparam logic [ADDR_W-1:0] RA_IE_SET = 4'd2;
    localparam logic [ADDR_W-1:0] RA_IE_CLR = 4'd3;
    localparam logic [ADDR_W-1:0] RA_SEL    = 4'd4;
    localparam logic [ADDR_W-1:0] RA_RSEC   = 4'd5;
    localparam logic [ADDR_W-1:0] RA_RNS    = 4'd6;
    localparam logic [ADDR_W-1:0] RA_FSEC   = 4'd7;
    localparam logic [ADDR_W-1:0] RA_FNS    = 4'd8;

    typedef enum logic [1:0] {
        CS_OFF   = 2'd0,
        CS_ARMED = 2'd1,
        CS_HELD  = 2'd2
    } cap_state_e;
endpackage

// File: rtl/evcap_sync.sv
module evcap_sync #(
    parameter int NCH = evcap_pkg::NUM_CH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pin_i,
    output logic [NCH-1:0] rise_o,
    output logic [NCH-1:0] fall_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic meta_q, sync_q, prev_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pin_i[c];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end
        assign rise_o[c] =  sync_q & ~prev_q;
        assign fall_o[c] = ~sync_q &  prev_q;
    end
endmodule

// File: rtl/evcap_edge_unit.sv
module evcap_edge_unit
    import evcap_pkg::*;
#(
    parameter int SW = SEC_W,
    parameter int NW = NS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          lock_i,
    input  logic          edge_i,
    input  logic          clr_i,
    input  logic [SW-1:0] sec_i,
    input  logic [NW-1:0] ns_i,
    output logic          pend_o,
    output logic [SW-1:0] sec_o,
    output logic [NW-1:0] ns_o
);
    cap_state_e    state_q, state_d;
    logic          pend_q, pend_d;
    logic          take;
    logic          refuse;
    logic [SW-1:0] sec_q;
    logic [NW-1:0] ns_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_OFF;
        else        state_q <= state_d;
    end

    // output/action logic
    always_comb begin
        refuse = (state_q == CS_HELD) && lock_i && !clr_i;
        take   = en_i && edge_i && !refuse;
        pend_d = take | (pend_q & ~clr_i);
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_OFF: begin
                if (en_i) state_d = (lock_i && pend_d) ? CS_HELD : CS_ARMED; // T_ENABLE
            end
            CS_ARMED: begin
                if (!en_i)                 state_d = CS_OFF;                  // T_DISABLE
                else if (lock_i && pend_d) state_d = CS_HELD;                 // T_LOCK
            end
            CS_HELD: begin
                if (!en_i)                   state_d = CS_OFF;                // T_DISABLE
                else if (!lock_i || !pend_d) state_d = CS_ARMED;              // T_RELEASE
            end
            default: state_d = CS_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            sec_q  <= '0;
            ns_q   <= '0;
        end else begin
            pend_q <= pend_d;
            if (take) begin
                sec_q <= sec_i;
                ns_q  <= ns_i;
            end
        end
    end

    assign pend_o = pend_q;
    assign sec_o  = sec_q;
    assign ns_o   = ns_q;
endmodule

// File: rtl/evcap_regs.sv
module evcap_regs
    import evcap_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  bus_wr,
    input  logic [ADDR_W-1:0]                     bus_addr,
    input  logic [DATA_W-1:0]                     bus_wdata,
    output logic [DATA_W-1:0]                     bus_rdata,
    input  logic [1:0][NCH-1:0]                   pend_i,
    input  logic [1:0][NCH-1:0][SEC_W-1:0]        sec_i,
    input  logic [1:0][NCH-1:0][NS_W-1:0]         ns_i,
    output logic [1:0][NCH-1:0]                   en_o,
    output logic [1:0][NCH-1:0]                   lock_o,
    output logic [1:0][NCH-1:0]                   clr_o,
    output logic                                  irq
);
    localparam int ZEXT = DATA_W - NS_W;

    logic [DATA_W-1:0]     cfg_q;
    logic [SEL_W-1:0]      sel_q;
    logic [1:0][NCH-1:0]   ien_q;
    logic [1:0][NCH-1:0]   wr_bits;

    for (genvar e = 0; e < 2; e++) begin : g_dir
        assign en_o[e]    = cfg_q[e*FIELD_W +: NCH];
        assign lock_o[e]  = cfg_q[LOCK_LSB + e*FIELD_W +: NCH];
        assign wr_bits[e] = bus_wdata[STAT_LSB + e*FIELD_W +: NCH];
        assign clr_o[e]   = (bus_wr && bus_addr == RA_STAT) ? wr_bits[e] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            sel_q <= '0;
            ien_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == RA_CFG)    cfg_q <= bus_wdata;
            if (bus_addr == RA_SEL)    sel_q <= bus_wdata[SEL_LSB +: SEL_W];
            if (bus_addr == RA_IE_SET) ien_q <= ien_q | wr_bits;
            if (bus_addr == RA_IE_CLR) ien_q <= ien_q & ~wr_bits;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_CFG:    bus_rdata = cfg_q;
            RA_STAT:   bus_rdata[STAT_LSB +: 2*NCH] = pend_i;
            RA_IE_SET,
            RA_IE_CLR: bus_rdata[STAT_LSB +: 2*NCH] = ien_q;
            RA_SEL:    bus_rdata[SEL_LSB +: SEL_W] = sel_q;
            RA_RSEC:   bus_rdata = sec_i[0][sel_q];
            RA_RNS:    bus_rdata = {{ZEXT{1'b0}}, ns_i[0][sel_q]};
            RA_FSEC:   bus_rdata = sec_i[1][sel_q];
            RA_FNS:    bus_rdata = {{ZEXT{1'b0}}, ns_i[1][sel_q]};
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = |(pend_i & ien_q);
endmodule

// File: rtl/edge_stamp_capture.sv
module edge_stamp_capture
    import evcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        ev_in,
    input  logic [31:0]       ltc_sec,
    input  logic [29:0]       ltc_ns,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    localparam int NCH = NUM_CH;

    logic [1:0][NCH-1:0]            pulse_w;
    logic [1:0][NCH-1:0]            en_w, lock_w, clr_w, pend_w;
    logic [1:0][NCH-1:0][SEC_W-1:0] cap_sec_w;
    logic [1:0][NCH-1:0][NS_W-1:0]  cap_ns_w;

    evcap_sync #(.NCH(NCH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ev_in),
        .rise_o (pulse_w[0]),
        .fall_o (pulse_w[1])
    );

    for (genvar e = 0; e < 2; e++) begin : g_dir
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            evcap_edge_unit #(.SW(SEC_W), .NW(NS_W)) u_unit (
                .clk    (clk),
                .rst_n  (rst_n),
                .en_i   (en_w[e][c]),
                .lock_i (lock_w[e][c]),
                .edge_i (pulse_w[e][c]),
                .clr_i  (clr_w[e][c]),
                .sec_i  (ltc_sec),
                .ns_i   (ltc_ns),
                .pend_o (pend_w[e][c]),
                .sec_o  (cap_sec_w[e][c]),
                .ns_o   (cap_ns_w[e][c])
            );
        end
    end

    evcap_regs #(.NCH(NCH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pend_i    (pend_w),
        .sec_i     (cap_sec_w),
        .ns_i      (cap_ns_w),
        .en_o      (en_w),
        .lock_o    (lock_w),
        .clr_o     (clr_w),
        .irq       (irq)
    );
endmodule

// File: rtl/evcap_checker.sv
module evcap_checker
    import evcap_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           bus_wr,
    input logic [ADDR_W-1:0]              bus_addr,
    input logic [DATA_W-1:0]              bus_wdata,
    input logic                           irq,
    input logic [1:0][NCH-1:0]            pulse,
    input logic [1:0][NCH-1:0]            en,
    input logic [1:0][NCH-1:0]            lock,
    input logic [1:0][NCH-1:0]            pend,
    input logic [1:0][NCH-1:0]            ien,
    input logic [1:0][NCH-1:0][SEC_W-1:0] cap_sec,
    input logic [1:0][NCH-1:0][NS_W-1:0]  cap_ns
);
    for (genvar e = 0; e < 2; e++) begin : g_dir
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            localparam int BIT = STAT_LSB + e*FIELD_W + c;

            assert_lock_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(en[e][c] && lock[e][c]) && lock[e][c] && pend[e][c] &&
                 !(bus_wr && bus_addr == RA_STAT && bus_wdata[BIT]))
                |=> ($stable(cap_sec[e][c]) && $stable(cap_ns[e][c])));

            assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
                !en[e][c] |=> ($stable(cap_sec[e][c]) && !$rose(pend[e][c])));

            assert_capture_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(cap_ns[e][c]) |-> $past(pulse[e][c] && en[e][c]));

            assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && bus_addr == RA_STAT && bus_wdata[BIT] && !pulse[e][c])
                |=> !pend[e][c]);

            assert_ien_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && bus_addr == RA_IE_SET && bus_wdata[BIT]) |=> ien[e][c]);

            assert_ien_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && bus_addr == RA_IE_CLR && bus_wdata[BIT]) |=> !ien[e][c]);
        end
    end

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend != '0 && ien != '0));
endmodule

bind edge_stamp_capture evcap_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .pulse     (pulse_w),
    .en        (en_w),
    .lock      (lock_w),
    .pend      (pend_w),
    .ien       (u_regs.ien_q),
    .cap_sec   (cap_sec_w),
    .cap_ns    (cap_ns_w)
);

// File: tb/edge_stamp_capture_bench.sv
`timescale 1ns/1ps
module edge_stamp_capture_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ev_in = '0;
    logic [31:0] ltc_sec = '0;
    logic [29:0] ltc_ns = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    edge_stamp_capture u_edge_stamp_capture (
        .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .ltc_sec(ltc_sec), .ltc_ns(ltc_ns),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] t_sec(int ch, int e, int k);
        return 32'h1000_0000 + 32'(ch * 256 + e * 16 + k);
    endfunction
    function automatic logic [29:0] t_ns(int ch, int e, int k);
        return 30'h2000_0000 | 30'(ch * 1000 + e * 100 + k);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // drive a pin level with a given time value, wait until capture has landed
    task automatic pin(int ch, logic lvl, logic [31:0] s, logic [29:0] n);
        @(negedge clk);
        ltc_sec = s; ltc_ns = n; ev_in[ch] = lvl;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_caps(int ch, int e, logic [31:0] s, logic [29:0] n, string req);
        logic [31:0] d;
        wr(4'd4, 32'(ch) << 8);
        rd(e ? 4'd7 : 4'd5, d); chk(req, d, s);
        rd(e ? 4'd8 : 4'd6, d); chk(req, d, {2'b00, n});
    endtask

    initial begin
        #(8ns * 150000);
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 9; a++) begin
            rd(4'(a), d); chk("R1 reset read", d, 32'h0);
        end
        chk("R1 irq reset", {31'b0, irq}, 32'h0);

        // sweep: all pins, both directions, no locks
        wr(4'd0, 32'h0000_FFFF);
        wr(4'd2, 32'hFFFF_0000);
        for (int ch = 0; ch < 8; ch++) begin
            pin(ch, 1'b1, t_sec(ch, 0, 0), t_ns(ch, 0, 0));
            rd(4'd1, d); chk("R2 rise status", d[16 + ch], 32'h1);
            chk("R9 irq after event", {31'b0, irq}, 32'h1);
            expect_caps(ch, 0, t_sec(ch, 0, 0), t_ns(ch, 0, 0), "R2 rise capture");
            pin(ch, 1'b0, t_sec(ch, 1, 0), t_ns(ch, 1, 0));
            rd(4'd1, d); chk("R3 fall status", d[24 + ch], 32'h1);
            expect_caps(ch, 1, t_sec(ch, 1, 0), t_ns(ch, 1, 0), "R3 fall capture");
        end
        // R10: each channel still holds its own values
        for (int ch = 0; ch < 8; ch++) begin
            expect_caps(ch, 0, t_sec(ch, 0, 0), t_ns(ch, 0, 0), "R10 select rise");
            expect_caps(ch, 1, t_sec(ch, 1, 0), t_ns(ch, 1, 0), "R10 select fall");
        end
        rd(4'd4, d); chk("R10 select readback", d, 32'h0000_0700);

        // R7: write-one-to-clear
        rd(4'd1, d); chk("R7 all pending", d, 32'hFFFF_0000);
        wr(4'd1, 32'h0000_FFFF);
        rd(4'd1, d); chk("R7 zero bits keep", d, 32'hFFFF_0000);
        wr(4'd1, 32'h00FF_0000);
        rd(4'd1, d); chk("R7 clear rise", d, 32'hFF00_0000);

        // R8 / R9: enable set/clear
        wr(4'd3, 32'hFF00_0000);
        rd(4'd2, d); chk("R8 read via set", d, 32'h00FF_0000);
        rd(4'd3, d); chk("R8 read via clr", d, 32'h00FF_0000);
        chk("R9 irq masked", {31'b0, irq}, 32'h0);
        wr(4'd2, 32'h0000_0000);
        rd(4'd2, d); chk("R8 zero set no effect", d, 32'h00FF_0000);
        wr(4'd3, 32'h00FF_0000);
        rd(4'd2, d); chk("R8 clear all", d, 32'h0);
        wr(4'd2, 32'h0100_0000);
        chk("R9 irq one enable", {31'b0, irq}, 32'h1);
        wr(4'd1, 32'hFFFF_0000);
        chk("R9 irq after clear", {31'b0, irq}, 32'h0);

        // R6: no lock, overwrite while pending
        wr(4'd0, 32'h0000_0008);
        pin(3, 1'b1, t_sec(3, 0, 1), t_ns(3, 0, 1));
        pin(3, 1'b0, t_sec(3, 1, 9), t_ns(3, 1, 9));
        pin(3, 1'b1, t_sec(3, 0, 2), t_ns(3, 0, 2));
        expect_caps(3, 0, t_sec(3, 0, 2), t_ns(3, 0, 2), "R6 overwrite");
        expect_caps(3, 1, t_sec(3, 1, 0), t_ns(3, 1, 0), "R4 fall disabled ch3");
        rd(4'd1, d); chk("R6 status", d, 32'h0008_0000);
        pin(3, 1'b0, 32'h0, 30'h0);
        wr(4'd1, 32'hFFFF_0000);

        // R5: lock holds first capture until status cleared
        wr(4'd0, 32'h0004_0004);
        pin(2, 1'b1, t_sec(2, 0, 3), t_ns(2, 0, 3));
        pin(2, 1'b0, 32'h0, 30'h0);
        pin(2, 1'b1, t_sec(2, 0, 4), t_ns(2, 0, 4));
        expect_caps(2, 0, t_sec(2, 0, 3), t_ns(2, 0, 3), "R5 locked hold");
        rd(4'd1, d); chk("R5 status pending", d, 32'h0004_0000);
        wr(4'd1, 32'h0004_0000);
        rd(4'd1, d); chk("R5 status cleared", d, 32'h0);
        pin(2, 1'b0, 32'h0, 30'h0);
        pin(2, 1'b1, t_sec(2, 0, 5), t_ns(2, 0, 5));
        expect_caps(2, 0, t_sec(2, 0, 5), t_ns(2, 0, 5), "R5 recapture");
        rd(4'd1, d); chk("R5 status again", d, 32'h0004_0000);
        pin(2, 1'b0, 32'h0, 30'h0);
        wr(4'd1, 32'hFFFF_0000);

        // R4: only falling enabled on pin 5
        wr(4'd0, 32'h0000_2000);
        pin(5, 1'b1, t_sec(5, 0, 7), t_ns(5, 0, 7));
        rd(4'd1, d); chk("R4 rise disabled status", d, 32'h0);
        expect_caps(5, 0, t_sec(5, 0, 0), t_ns(5, 0, 0), "R4 rise disabled capture");
        pin(5, 1'b0, t_sec(5, 1, 7), t_ns(5, 1, 7));
        rd(4'd1, d); chk("R3 fall only status", d, 32'h2000_0000);
        expect_caps(5, 1, t_sec(5, 1, 7), t_ns(5, 1, 7), "R3 fall only capture");
        wr(4'd1, 32'hFFFF_0000);

        // R4: everything disabled
        wr(4'd0, 32'h0);
        pin(1, 1'b1, t_sec(1, 0, 8), t_ns(1, 0, 8));
        pin(1, 1'b0, t_sec(1, 1, 8), t_ns(1, 1, 8));
        rd(4'd1, d); chk("R4 all disabled status", d, 32'h0);
        expect_caps(1, 0, t_sec(1, 0, 0), t_ns(1, 0, 0), "R4 all disabled rise");
        expect_caps(1, 1, t_sec(1, 1, 0), t_ns(1, 1, 0), "R4 all disabled fall");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule